// File: doc/BRIEF.md
# Coprocessor Null-Response Sequencer

This block is the main-processor controller for the wait-and-decide phase of a coprocessor instruction. After `start_i` it reads a 5-bit response word from the coprocessor over a request/acknowledge handshake. It decodes the word together with the local trace-pending and interrupt-pending flags. It then either ends the instruction or goes back to reading the response. When the word asks for the program counter, the block first sends the instruction address over a second handshake. It then treats that bit as cleared and acts on the other bits.

The response word packs its bits as CA (bit 4), PC (bit 3), IA (bit 2), PF (bit 1) and TF (bit 0). CA means the coprocessor is still busy. IA allows interrupt service while waiting. PF means the coprocessor has finished. TF is the true/false result for conditional instructions. Every reread is a new handshake. When interrupt service is needed before a reread, the block raises `irq_svc_o` and waits for `irq_done_i`. Each instruction ends with a one-cycle `done_o` pulse and an action code on `act_o`. A counter of consecutive rereads ends a coprocessor that never stops answering busy, and reports it as a protocol error.

Top module: `copro_null_seq`

## Requirements
- R1: Reset leaves `resp_req_o`, `addr_req_o`, `irq_svc_o`, `done_o` and `err_o` low. `start_i` in idle raises `resp_req_o` on the next cycle. `start_i` and `cond_i` are ignored while an instruction is in progress.
- R2: `resp_req_o` stays high until `resp_ack_i`, and the word on `resp_data_i` is captured in that cycle. Each reread is a new request/acknowledge transaction.
- R3: A captured word with PC (bit 3) set raises `addr_req_o` on the next cycle and holds it until `addr_ack_i`. This happens exactly once per such word, before any other action.
- R4: CA=1 with IA=0 causes a reread, and `irq_svc_o` is never raised.
- R5: CA=1 with IA=1 causes a reread. If `irq_pend_i` is high, `irq_svc_o` is held first until `irq_done_i`, and the reread starts on the next cycle.
- R6: In a general instruction, CA=0 with PF=0 causes a reread, with R5 interrupt service, when `trace_pend_i` is high. Otherwise it finishes with action NEXT.
- R7: In a general instruction, CA=0 with PF=1 finishes with action EXC when `trace_pend_i` or `irq_pend_i` is high, and with action NEXT otherwise.
- R8: In a conditional instruction (`cond_i`=1 at start), CA=1 behaves as in a general instruction. CA=0 finishes with action COND and `cond_o` equal to TF.
- R9: Each finish gives a `done_o` pulse of exactly one cycle. The codes on `act_o` are 0 NEXT, 1 EXC, 2 COND and 3 ABORT. `cond_o` is 0 for any action other than COND.
- R10: After MAX_REREADS consecutive rereads, the next reread decision finishes with action ABORT and sets `err_o`. `err_o` stays high until the next accepted `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the response phase of an instruction |
| cond_i | input | 1 | Instruction is conditional (sampled at start) |
| trace_pend_i | input | 1 | A trace is pending |
| irq_pend_i | input | 1 | An interrupt is pending |
| resp_req_o | output | 1 | Request to read the response word |
| resp_ack_i | input | 1 | Response word valid |
| resp_data_i | input | 5 | Response word {CA,PC,IA,PF,TF} |
| addr_req_o | output | 1 | Request to write the instruction address |
| addr_ack_i | input | 1 | Address write accepted |
| irq_svc_o | output | 1 | Service pending interrupts before the reread |
| irq_done_i | input | 1 | Interrupt service finished |
| done_o | output | 1 | One-cycle completion pulse |
| act_o | output | 2 | Final action code |
| cond_o | output | 1 | Condition result for COND |
| err_o | output | 1 | Sticky protocol error after a reread timeout |

## Verification
The assertions check the handshake rules on every cycle. They cover request hold until acknowledge and the address write that follows a PC word. They also cover interrupt-service hold and the reread that follows it, the single-cycle done pulse, and that the error flag persists. The action chosen for each combination of CA, PC, IA, PF and TF, with trace and interrupt state and the instruction kind, can only be seen from the bench. The bench sweeps all 256 combinations and counts reads, address writes and interrupt services for each. The reread timeout and the ignored restart are also shown only by dedicated bench scenarios.

// File: rtl/copro_null_pkg.sv
package copro_null_pkg;
  typedef struct packed {
    logic ca;
    logic pc;
    logic ia;
    logic pf;
    logic tf;
  } resp_t;

  typedef enum logic [1:0] {
    ACT_NEXT  = 2'd0,
    ACT_EXC   = 2'd1,
    ACT_COND  = 2'd2,
    ACT_ABORT = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    K_FINISH,
    K_REREAD,
    K_SVC_REREAD
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_ADDR,
    S_EVAL,
    S_SVC
  } state_e;
endpackage

// File: rtl/copro_null_decode.sv
module copro_null_decode
  import copro_null_pkg::*;
(
  input  resp_t word_i,
  input  logic  cond_i,
  input  logic  trace_i,
  input  logic  irq_i,
  output kind_e kind_o,
  output act_e  act_o
);
  logic svc;
  assign svc = word_i.ia & irq_i;

  always_comb begin
    kind_o = K_FINISH;
    act_o  = ACT_NEXT;
    if (word_i.ca) begin
      kind_o = svc ? K_SVC_REREAD : K_REREAD;
    end else if (cond_i) begin
      act_o = ACT_COND;
    end else if (word_i.pf) begin
      act_o = (trace_i | irq_i) ? ACT_EXC : ACT_NEXT;
    end else if (trace_i) begin
      kind_o = svc ? K_SVC_REREAD : K_REREAD;
    end
  end
endmodule

// File: rtl/copro_null_wdog.sv
module copro_null_wdog #(
  parameter int unsigned MAX_REREADS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic limit_o
);
  localparam int unsigned CW = $clog2(MAX_REREADS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_REREADS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign limit_o = (cnt_q == LIMIT);
endmodule

// File: rtl/copro_null_seq.sv
module copro_null_seq
  import copro_null_pkg::*;
#(
  parameter int unsigned MAX_REREADS = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       cond_i,
  input  logic       trace_pend_i,
  input  logic       irq_pend_i,
  output logic       resp_req_o,
  input  logic       resp_ack_i,
  input  logic [4:0] resp_data_i,
  output logic       addr_req_o,
  input  logic       addr_ack_i,
  output logic       irq_svc_o,
  input  logic       irq_done_i,
  output logic       done_o,
  output logic [1:0] act_o,
  output logic       cond_o,
  output logic       err_o
);
  state_e state_q;
  resp_t  word_q;
  logic   cond_q, done_q, cres_q, err_q;
  act_e   act_q;
  kind_e  dec_kind;
  act_e   dec_act;
  logic   wd_limit, wd_clr, wd_inc, is_eval, accept;

  copro_null_decode u_dec (
    .word_i  (word_q),
    .cond_i  (cond_q),
    .trace_i (trace_pend_i),
    .irq_i   (irq_pend_i),
    .kind_o  (dec_kind),
    .act_o   (dec_act)
  );

  assign is_eval = (state_q == S_EVAL);
  assign accept  = (state_q == S_IDLE) && start_i;
  assign wd_clr  = accept;
  assign wd_inc  = is_eval && (dec_kind != K_FINISH) && !wd_limit;

  copro_null_wdog #(.MAX_REREADS(MAX_REREADS)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wd_clr),
    .inc_i   (wd_inc),
    .limit_o (wd_limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      word_q  <= '0;
      cond_q  <= 1'b0;
      done_q  <= 1'b0;
      cres_q  <= 1'b0;
      err_q   <= 1'b0;
      act_q   <= ACT_NEXT;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_READ;
          cond_q  <= cond_i;
          err_q   <= 1'b0;
        end
        S_READ: if (resp_ack_i) begin
          word_q  <= resp_t'(resp_data_i);
          state_q <= resp_data_i[3] ? S_ADDR : S_EVAL;
        end
        S_ADDR: if (addr_ack_i) begin
          // address sent: PC treated as cleared, remaining bits still pending
          word_q.pc <= 1'b0;
          state_q   <= S_EVAL;
        end
        S_EVAL: begin
          if (dec_kind == K_FINISH) begin
            done_q  <= 1'b1;
            act_q   <= dec_act;
            cres_q  <= (dec_act == ACT_COND) && word_q.tf;
            state_q <= S_IDLE;
          end else if (wd_limit) begin
            done_q  <= 1'b1;
            act_q   <= ACT_ABORT;
            cres_q  <= 1'b0;
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= (dec_kind == K_SVC_REREAD) ? S_SVC : S_READ;
          end
        end
        S_SVC: if (irq_done_i) state_q <= S_READ;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign resp_req_o = (state_q == S_READ);
  assign addr_req_o = (state_q == S_ADDR);
  assign irq_svc_o  = (state_q == S_SVC);
  assign done_o     = done_q;
  assign act_o      = act_q;
  assign cond_o     = cres_q;
  assign err_o      = err_q;
endmodule

// File: rtl/copro_null_seq_chk.sv
module copro_null_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       irq_pend_i,
  input logic       resp_req_o,
  input logic       resp_ack_i,
  input logic [4:0] resp_data_i,
  input logic       addr_req_o,
  input logic       addr_ack_i,
  input logic       irq_svc_o,
  input logic       irq_done_i,
  input logic       done_o,
  input logic       err_o
);
  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_req_o && !resp_ack_i |=> resp_req_o);

  a_r3_pc_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_req_o && resp_ack_i && resp_data_i[3] |=> addr_req_o);

  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_req_o && !addr_ack_i |=> addr_req_o);

  a_r3_addr_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_req_o && addr_ack_i |=> !addr_req_o && !resp_req_o);

  a_r5_svc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_svc_o && !irq_done_i |=> irq_svc_o);

  a_r5_svc_reread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_svc_o && irq_done_i |=> resp_req_o);

  a_r5_svc_needs_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_svc_o) |-> $past(irq_pend_i));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !resp_req_o && !addr_req_o && !irq_svc_o);

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o);
endmodule

bind copro_null_seq copro_null_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .irq_pend_i  (irq_pend_i),
  .resp_req_o  (resp_req_o),
  .resp_ack_i  (resp_ack_i),
  .resp_data_i (resp_data_i),
  .addr_req_o  (addr_req_o),
  .addr_ack_i  (addr_ack_i),
  .irq_svc_o   (irq_svc_o),
  .irq_done_i  (irq_done_i),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/copro_null_seq_bench.sv
module copro_null_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, cond_i = 0, trace_i = 0, irq_i = 0;
  logic resp_req, resp_ack = 0, addr_req, addr_ack = 0, irq_svc, irq_done = 0;
  logic [4:0] resp_data = '0;
  logic done, cond_res, err;
  logic [1:0] act;

  copro_null_seq #(.MAX_REREADS(MAXR)) u_copro_null_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .cond_i(cond_i),
    .trace_pend_i(trace_i), .irq_pend_i(irq_i),
    .resp_req_o(resp_req), .resp_ack_i(resp_ack), .resp_data_i(resp_data),
    .addr_req_o(addr_req), .addr_ack_i(addr_ack),
    .irq_svc_o(irq_svc), .irq_done_i(irq_done),
    .done_o(done), .act_o(act), .cond_o(cond_res), .err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [4:0] first_w = '0, term_w = '0;
  int n_reads = 0, n_addr = 0, n_irq = 0, svc_wait = 0;
  logic got_done = 0, got_cond = 0;
  logic [1:0] got_act = '0;

  // responder: coprocessor and interrupt unit model
  initial begin
    forever begin
      @(negedge clk);
      resp_ack = 0; addr_ack = 0; irq_done = 0;
      if (resp_req) begin
        resp_ack  = 1;
        resp_data = (n_reads == 0) ? first_w : term_w;
        n_reads++;
      end
      if (addr_req) begin
        addr_ack = 1;
        n_addr++;
      end
      if (irq_svc) begin
        if (svc_wait == 1) begin
          irq_done = 1; n_irq++; svc_wait = 0;
        end else svc_wait++;
      end
      if (done) begin
        got_done = 1; got_act = act; got_cond = cond_res;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run(input logic [4:0] w, input logic [4:0] t, input logic c,
                     input logic tr, input logic ir, input int busy_kick);
    @(negedge clk); #1;
    first_w = w; term_w = t; n_reads = 0; n_addr = 0; n_irq = 0;
    svc_wait = 0; got_done = 0; cond_i = c; trace_i = tr; irq_i = ir; start_i = 1;
    @(negedge clk); #1;
    start_i = 0;
    for (int k = 0; k < 400 && !got_done; k++) begin
      if (busy_kick != 0 && k == busy_kick) begin
        start_i = 1; cond_i = ~c;
      end else start_i = 0;
      @(negedge clk); #1;
    end
    start_i = 0;
    chk("R9 done seen", got_done, 1);
    @(negedge clk); #1;
    chk("R9 done one cycle", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not end)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset resp_req", resp_req, 0);
    chk("R1 reset addr_req", addr_req, 0);
    chk("R1 reset irq_svc", irq_svc, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset err", err, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: start raises resp_req on the next cycle
    @(negedge clk); #1;
    first_w = 5'b00010; term_w = 5'b00010; n_reads = 0; got_done = 0;
    cond_i = 0; trace_i = 0; irq_i = 0; start_i = 1;
    @(posedge clk); #1;
    start_i = 0;
    chk("R1 req after start", resp_req, 1);
    for (int k = 0; k < 20 && !got_done; k++) begin @(negedge clk); #1; end
    chk("R7 plain finish act", got_act, 0);

    // full sweep of word, kind, trace and interrupt state
    for (int wi = 0; wi < 32; wi++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int ti = 0; ti < 2; ti++) begin
          for (int ii = 0; ii < 2; ii++) begin
            logic ca, pc, ia, pf, tf, reread;
            int e_act, e_cond, e_reads, e_irq;
            string tag;
            {ca, pc, ia, pf, tf} = 5'(wi);
            reread  = ca || (ci == 0 && !pf && ti == 1);
            e_reads = reread ? 2 : 1;
            e_irq   = (reread && ia && ii == 1) ? 1 : 0;
            e_cond  = 0;
            if (ci == 1) begin
              e_act = 2; e_cond = reread ? 0 : int'(tf);
              tag = "R8";
            end else begin
              if (reread || pf) e_act = (ti == 1 || ii == 1) ? 1 : 0;
              else e_act = 0;
              tag = ca ? (ia ? "R5" : "R4") : (pf ? "R7" : "R6");
            end
            run(5'(wi), (ci == 1) ? 5'b00000 : 5'b00010,
                1'(ci), 1'(ti), 1'(ii), 0);
            chk({tag, " act"}, got_act, e_act);
            chk("R8 cond result", got_cond, e_cond);
            chk("R2 reads", n_reads, e_reads);
            chk("R3 addr writes", n_addr, int'(pc));
            chk("R5 irq services", n_irq, e_irq);
          end
        end
      end
    end

    // R10 timeout with a restart attempt while busy (R1 ignored)
    run(5'b10000, 5'b10000, 1'b0, 1'b0, 1'b0, 5);
    chk("R10 abort act", got_act, 3);
    chk("R10 reads", n_reads, MAXR + 1);
    chk("R10 err set", err, 1);
    chk("R4 no service", n_irq, 0);
    repeat (3) @(negedge clk);
    #1;
    chk("R10 err sticky", err, 1);
    chk("R1 no restart", resp_req, 0);

    // R10 timeout with interrupt service on every reread
    run(5'b11100, 5'b10100, 1'b1, 1'b0, 1'b1, 0);
    chk("R10 abort act svc", got_act, 3);
    chk("R10 svc reads", n_reads, MAXR + 1);
    chk("R5 svc count", n_irq, MAXR);
    chk("R3 addr once", n_addr, 1);
    chk("R9 abort cond", got_cond, 0);

    // R10 err cleared by the next start
    run(5'b00011, 5'b00011, 1'b1, 1'b0, 1'b0, 0);
    chk("R10 err cleared", err, 0);
    chk("R8 cond true", got_cond, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule